// File: doc/BRIEF.md
# Three-Mode Counter/Timer

This block is a 16-bit down-counter whose reload value is assembled from two byte-wide preset registers. It runs in one of three modes. In timer mode it reloads itself at every terminal count and toggles its output, which gives a free-running square wave. In counter mode it runs once from the preset down to zero, halts there, and reports the finished delay. In time-out mode it is driven by receiver activity. Each received character reloads and restarts the count. If the count reaches zero before the next character arrives, the block reports that the incoming data has paused.

A status flag is raised each time the count expires. The flag stays set until a stop command clears it. The toggling output is meant to drive an output pin, or to serve as a 16x clock for a serial receiver or transmitter. Software controls the block through a 3-bit command code with an 8-bit data byte, one command per clock. A read command latches both halves of the live count into a snapshot register in the same clock, so the upper and lower bytes always belong to the same count value. The count steps once per clock.

Top module: `ctr3_top`

## Requirements
- R1: After reset the count, the preset, the snapshot and the output are all zero, the flag is clear, the counter is halted and the mode is counter mode.
- R2: Command code 1 writes cmdData into the low preset byte and code 2 writes it into the high preset byte. A preset write does not disturb a count that is already running.
- R3: Command code 3 (start) loads the preset into the count, sets running and forces the output to 0. It selects timer mode when cmdData bit 0 is 1 and counter mode when bit 0 is 0, and this also ends time-out mode.
- R4: While running in timer mode with preset P ≥ 1, the count steps down once per clock. When the count is 1 or less, the next clock reloads P, toggles the output and sets the flag. Each half period is therefore P clocks, and a preset of 0 behaves like 1.
- R5: While running in counter mode, the count steps down to zero. At a count of 1 or less, the next clock writes zero, sets the flag and halts the counter. The output does not change in counter or time-out mode.
- R6: Command code 4 (stop) halts the count at its present value and clears the flag.
- R7: Command code 5 (read) copies the count as it stood before that clock edge into the snapshot. Both bytes are updated in the same clock.
- R8: Command code 6 enters time-out mode in a halted state. Each receive strobe then reloads the preset and starts counting. If the count expires before the next strobe, the flag is set and the counter halts at zero.
- R9: Command code 7 leaves time-out mode, selects counter mode and halts the counter. Later receive strobes have no effect.
- R10: Receive strobes have no effect on the count, the output or the flag in timer mode or counter mode.
- R11: When command 3, 4, 6 or 7 arrives in the same clock as a receive strobe or a terminal count, the command takes effect and the strobe or terminal event is dropped for that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdOp | input | 3 | Command code; 0 means idle |
| cmdData | input | 8 | Data byte for preset writes; bit 0 picks the mode on start |
| rxCharStb | input | 1 | One-clock strobe for each character received |
| ctOut | output | 1 | Square-wave output (pin or 16x clock) |
| flag | output | 1 | Expiry status flag |
| running | output | 1 | Counter is active |
| snapHi | output | 8 | Snapshot, upper byte |
| snapLo | output | 8 | Snapshot, lower byte |

## Verification
Every output is a plain register. The effect of a command or strobe applied before clock edge k appears just after edge k. The exception is the terminal event: it appears on the edge after the count has reached 1 or less, so in timer mode the output toggles P clocks after the start. The bench has a behavioural model that applies the same rules at each rising edge. It compares all five outputs at the following falling edge, which is half a cycle after the registers settle and before any new stimulus could matter. Each comparison is tagged with the requirement that the current stimulus phase exercises.

// File: rtl/ctr3_pkg.sv
package ctr3_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_WR_LO  = 3'd1,
    OP_WR_HI  = 3'd2,
    OP_START  = 3'd3,
    OP_STOP   = 3'd4,
    OP_READ   = 3'd5,
    OP_TO_SET = 3'd6,
    OP_TO_CLR = 3'd7
  } ctr3_op_e;

  typedef enum logic [1:0] {
    M_CNT  = 2'd0,
    M_TMR  = 2'd1,
    M_TOUT = 2'd2
  } ctr3_mode_e;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic load;
    logic dec;
    logic zero;
    logic capture;
  } ctr3_strobe_t;
endpackage

// File: rtl/ctr3_dpath.sv
module ctr3_dpath
  import ctr3_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctr3_strobe_t      stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic              atTerm,
  output logic [BYTE_W-1:0] snapHi,
  output logic [BYTE_W-1:0] snapLo
);
  localparam int LANES = 2;
  localparam int CNT_W = LANES * BYTE_W;

  logic [CNT_W-1:0] preset;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] snap;
  logic [LANES-1:0] laneWr;

  assign laneWr = {stb.wrHi, stb.wrLo};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) preset[i*BYTE_W +: BYTE_W] <= '0;
      else if (laneWr[i]) preset[i*BYTE_W +: BYTE_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (stb.load) cnt <= preset;
    else if (stb.zero) cnt <= '0;
    else if (stb.dec) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) snap <= '0;
    else if (stb.capture) snap <= cnt;
  end

  assign atTerm = (cnt[CNT_W-1:1] == '0);
  assign snapHi = snap[CNT_W-1 -: BYTE_W];
  assign snapLo = snap[BYTE_W-1:0];

  assert_load_preset_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> cnt == $past(preset));
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dec && !stb.load && !stb.zero) |=> cnt == $past(cnt) - 1'b1);
  assert_snap_whole_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> snap == $past(cnt));
endmodule

// File: rtl/ctr3_ctrl.sv
module ctr3_ctrl
  import ctr3_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   cmdOp,
  input  logic         modeBit,
  input  logic         rxCharStb,
  input  logic         atTerm,
  output ctr3_strobe_t stb,
  output logic         ctOut,
  output logic         flag,
  output logic         running
);
  ctr3_op_e   opE;
  ctr3_mode_e mode;
  logic       isCtl, rxHit, term;

  always_comb begin
    opE   = ctr3_op_e'(cmdOp);
    isCtl = (opE == OP_START) || (opE == OP_STOP) ||
            (opE == OP_TO_SET) || (opE == OP_TO_CLR);
    rxHit = (mode == M_TOUT) && rxCharStb && !isCtl;
    term  = running && atTerm && !isCtl && !rxHit;
    stb.wrLo    = (opE == OP_WR_LO);
    stb.wrHi    = (opE == OP_WR_HI);
    stb.capture = (opE == OP_READ);
    stb.load    = (opE == OP_START) || rxHit || (term && mode == M_TMR);
    stb.zero    = term && (mode != M_TMR);
    stb.dec     = running && !atTerm && !isCtl && !rxHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= M_CNT;
      running <= 1'b0;
      flag    <= 1'b0;
      ctOut   <= 1'b0;
    end else begin
      case (opE)
        OP_START: begin
          mode    <= modeBit ? M_TMR : M_CNT;
          running <= 1'b1;
          ctOut   <= 1'b0;
        end
        OP_STOP: begin
          running <= 1'b0;
          flag    <= 1'b0;
        end
        OP_TO_SET: begin
          mode    <= M_TOUT;
          running <= 1'b0;
        end
        OP_TO_CLR: begin
          mode    <= M_CNT;
          running <= 1'b0;
        end
        default: begin
          if (rxHit) running <= 1'b1;
          else if (term) begin
            flag <= 1'b1;
            if (mode == M_TMR) ctOut <= ~ctOut;
            else running <= 1'b0;
          end
        end
      endcase
    end
  end

  assert_flag_from_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(running));
  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opE == OP_STOP) |=> (!flag && !running));
  assert_out_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode != M_TMR && opE != OP_START) |=> $stable(ctOut));
  assert_clr_halts_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opE == OP_TO_CLR) |=> !running);
endmodule

// File: rtl/ctr3_top.sv
module ctr3_top
  import ctr3_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              rxCharStb,
  output logic              ctOut,
  output logic              flag,
  output logic              running,
  output logic [BYTE_W-1:0] snapHi,
  output logic [BYTE_W-1:0] snapLo
);
  ctr3_strobe_t stb;
  logic         atTerm;

  ctr3_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .modeBit(cmdData[0]),
    .rxCharStb(rxCharStb), .atTerm(atTerm), .stb(stb),
    .ctOut(ctOut), .flag(flag), .running(running)
  );

  ctr3_dpath #(.BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cmdData),
    .atTerm(atTerm), .snapHi(snapHi), .snapLo(snapLo)
  );
endmodule

// File: tb/tb_ctr3_top.sv
module tb_ctr3_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [7:0] cmdData = 8'd0;
  logic       rxCharStb = 1'b0;
  logic       ctOut, flag, running;
  logic [7:0] snapHi, snapLo;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  ctr3_top dut (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdData(cmdData),
    .rxCharStb(rxCharStb), .ctOut(ctOut), .flag(flag), .running(running),
    .snapHi(snapHi), .snapLo(snapLo)
  );

  always #4 clk = ~clk;

  // behavioural reference: 0 counter, 1 timer, 2 time-out
  int mMode, mRun, mFlag, mOut, mCnt, mPre, mSnap;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mRun = 0; mFlag = 0; mOut = 0; mCnt = 0; mPre = 0; mSnap = 0;
    end else begin
      bit ctl;
      ctl = (cmdOp == 3) || (cmdOp == 4) || (cmdOp == 6) || (cmdOp == 7);
      case (cmdOp)
        3'd1: mPre = (mPre & 32'hFF00) | int'(cmdData);
        3'd2: mPre = (mPre & 32'h00FF) | (int'(cmdData) << 8);
        3'd3: begin mCnt = mPre; mRun = 1; mOut = 0; mMode = cmdData[0] ? 1 : 0; end
        3'd4: begin mRun = 0; mFlag = 0; end
        3'd5: mSnap = mCnt;
        3'd6: begin mMode = 2; mRun = 0; end
        3'd7: begin mMode = 0; mRun = 0; end
        default: ;
      endcase
      if (!ctl) begin
        if (mMode == 2 && rxCharStb) begin
          mCnt = mPre; mRun = 1;
        end else if (mRun == 1) begin
          if (mCnt <= 1) begin
            mFlag = 1;
            if (mMode == 1) begin mCnt = mPre; mOut = 1 - mOut; end
            else begin mCnt = 0; mRun = 0; end
          end else mCnt = mCnt - 1;
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("ctOut", int'(ctOut), mOut);
      chk("flag", int'(flag), mFlag);
      chk("running", int'(running), mRun);
      chk("snapshot", int'({snapHi, snapLo}), mSnap);
    end
  end

  task automatic step(input logic [2:0] o, input logic [7:0] d, input logic rx);
    @(negedge clk);
    cmdOp = o; cmdData = d; rxCharStb = rx;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 8'd0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset values
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset flag", int'(flag), 0);
    chk("reset out", int'(ctOut), 0);
    chk("reset running", int'(running), 0);
    chk("reset snap", int'({snapHi, snapLo}), 0);
    rstN = 1'b1;
    idle(3);

    // R2 and R4: timer with preset 5, reads while running
    curReq = "R2";
    step(3'd1, 8'd5, 0); step(3'd2, 8'd0, 0);
    curReq = "R4";
    step(3'd3, 8'd1, 0);
    idle(12);
    step(3'd5, 8'd0, 0);
    curReq = "R7";
    idle(3); step(3'd5, 8'd0, 0);
    curReq = "R10";
    for (int i = 0; i < 6; i++) step(3'd0, 8'd0, 1);
    curReq = "R4";
    idle(20);

    // R6: stop holds and clears flag
    curReq = "R6";
    step(3'd4, 8'd0, 0); idle(5); step(3'd5, 8'd0, 0); idle(3);

    // R5: counter mode with 16-bit preset 0x0103
    curReq = "R5";
    step(3'd1, 8'h03, 0); step(3'd2, 8'h01, 0);
    step(3'd3, 8'd0, 0);
    idle(100);
    curReq = "R7";
    step(3'd5, 8'd0, 0);
    curReq = "R2";
    step(3'd1, 8'h40, 0);
    curReq = "R10";
    step(3'd0, 8'd0, 1);
    curReq = "R5";
    idle(170);
    step(3'd5, 8'd0, 0); idle(4);

    // R8: time-out mode
    curReq = "R8";
    step(3'd1, 8'd10, 0); step(3'd2, 8'd0, 0);
    step(3'd4, 8'd0, 0);
    step(3'd6, 8'd0, 0); idle(3);
    for (int k = 0; k < 6; k++) begin step(3'd0, 8'd0, 1); idle(6); end
    step(3'd5, 8'd0, 0);
    idle(20);

    // R11: command wins over same-cycle strobe
    curReq = "R11";
    step(3'd4, 8'd0, 0);
    step(3'd0, 8'd0, 1); idle(3);
    step(3'd4, 8'd0, 1); idle(3);

    // R9: leave time-out mode, strobes ignored
    curReq = "R9";
    step(3'd7, 8'd0, 0); idle(2);
    for (int i = 0; i < 4; i++) step(3'd0, 8'd0, 1);
    idle(15);

    // R4: preset 0 and 1 toggle every clock
    curReq = "R4";
    step(3'd1, 8'd0, 0); step(3'd3, 8'd1, 0); idle(6);
    step(3'd1, 8'd1, 0); step(3'd3, 8'd1, 0); idle(6);
    curReq = "R3";
    step(3'd3, 8'd0, 0); idle(4);

    cmdOp = 3'd0; rxCharStb = 1'b0;
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule